// File: doc/BRIEF.md
# Banked Binary Point CPU-Interface Register Bank

This block holds the per-processor CPU-interface state of an interrupt controller: an 8-bit priority mask, two 3-bit binary point copies (a primary, secure copy and a non-secure/alias copy) and four 32-bit active-priority words. Every register is replicated once per processor. A single register port reaches all of them. Each access carries a processor index and a secure/non-secure attribute.

The block works out which binary point copy an access reaches from the security attribute and the build options. It raises each stored binary point to the minimum of its copy. It turns the alias address into a read-as-zero, write-ignored hole when grouping is absent or the access is non-secure. Build parameters set the processor count, the controller revision and the presence of security extensions. Grouping support is derived from the revision and from the security extensions. Acknowledge, end-of-interrupt, arbitration and the distributor lie outside the block.

Top module: `bpr_regbank`

## Requirements
- R1: After reset, for every processor, the priority mask, the primary binary point and all active-priority words read 0, and the alias binary point holds 1.
- R2: A write to offset 0x004 stores bits [7:0] of the data as the priority mask. A read of 0x004 returns it zero-extended.
- R3: At offset 0x008, a secure access, or any access when security extensions are absent, reaches the primary copy. A write stores bits [2:0] of the data with a minimum of 0.
- R4: At offset 0x008, a non-secure access with security extensions present reaches the alias copy. A write stores bits [2:0] of the data, raised to 1 when they are 0.
- R5: At offset 0x01c, with grouping supported and the access secure (or security extensions absent), reads and writes reach the alias copy. A write is raised to a minimum of 1.
- R6: At offset 0x01c, a non-secure access with security extensions present reads 0 and its write changes no state.
- R7: Offsets 0x0d0, 0x0d4, 0x0d8 and 0x0dc each hold a full 32-bit active-priority word. The index is (offset - 0x0d0)/4.
- R8: An access with processor index n reads and changes only the registers of processor n.
- R9: Any other offset, misaligned ones included, reads 0, and a write to it changes no register.
- R10: Read data appears on rdata_o at the first clock edge after the read request and holds until the next read. A write is visible to an access in the following cycle.
- R11: Grouping is supported when the revision is 2 or higher or security extensions are present. Without grouping, offset 0x01c reads 0 and ignores writes for every access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| cpu_i | input | CPU_W | Processor index of the access |
| secure_i | input | 1 | 1 = secure access |
| offset_i | input | 12 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |

## Verification
The assertions assume that cpu_i stays below the processor count whenever req_i is high. They also assume that a read's result is consumed in the cycle after it, before another read replaces it. The bench drives only the indices 0 and 1 into a two-processor build and lets one access complete before it issues the next. Three builds run side by side under the same stimulus: security with revision 2, no security with revision 2, and no security with revision 1. The same offset and attribute sweep therefore covers every routing and read-as-zero case.

// File: rtl/bpr_regbank_pkg.sv
package bpr_regbank_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned OFF_W     = 12;
  localparam int unsigned PMR_W     = 8;
  localparam int unsigned BP_W      = 3;
  localparam int unsigned NUM_APR   = 4;
  localparam int unsigned APR_IDX_W = $clog2(NUM_APR);

  localparam logic [OFF_W-1:0] OFF_PMR  = 12'h004;
  localparam logic [OFF_W-1:0] OFF_BP   = 12'h008;
  localparam logic [OFF_W-1:0] OFF_ABP  = 12'h01c;
  localparam logic [7:0]       APR_PAGE = 8'h0d;

  localparam logic [BP_W-1:0] MIN_BP_S  = 3'd0;
  localparam logic [BP_W-1:0] MIN_BP_NS = 3'd1;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_PMR,
    TGT_BP_S,
    TGT_BP_NS,
    TGT_APR
  } tgt_e;

  typedef struct packed {
    tgt_e                 tgt;
    logic [APR_IDX_W-1:0] apr_idx;
  } sel_t;

  function automatic logic [BP_W-1:0] clamp_bp(logic [BP_W-1:0] v, logic [BP_W-1:0] lo);
    return (v < lo) ? lo : v;
  endfunction
endpackage

// File: rtl/bpr_decode.sv
module bpr_decode
  import bpr_regbank_pkg::*;
#(
  parameter bit SEC_EXT    = 1'b1,
  parameter bit HAS_GROUPS = 1'b1
) (
  input  logic [OFF_W-1:0] offset_i,
  input  logic             secure_i,
  output sel_t             sel_o
);
  logic ns_view;

  always_comb begin
    ns_view       = SEC_EXT && !secure_i;
    sel_o.tgt     = TGT_NONE;
    sel_o.apr_idx = '0;
    unique case (offset_i)
      OFF_PMR: sel_o.tgt = TGT_PMR;
      OFF_BP:  sel_o.tgt = ns_view ? TGT_BP_NS : TGT_BP_S;
      OFF_ABP: if (HAS_GROUPS && !ns_view) sel_o.tgt = TGT_BP_NS;
      default: begin
        // active-priority words: 0x0d0..0x0dc, word aligned
        if (offset_i[OFF_W-1:4] == APR_PAGE && offset_i[1:0] == 2'b00) begin
          sel_o.tgt     = TGT_APR;
          sel_o.apr_idx = offset_i[2 +: APR_IDX_W];
        end
      end
    endcase
  end
endmodule

// File: rtl/bpr_cpu_bank.sv
module bpr_cpu_bank
  import bpr_regbank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  sel_t              sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [PMR_W-1:0]  pmr_o,
  output logic [BP_W-1:0]   bp_s_o,
  output logic [BP_W-1:0]   bp_ns_o,
  output logic [DATA_W-1:0] apr_o [NUM_APR]
);
  logic [PMR_W-1:0] pmr_q;
  logic [BP_W-1:0]  bp_s_q, bp_ns_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pmr_q   <= '0;
      bp_s_q  <= MIN_BP_S;
      bp_ns_q <= MIN_BP_NS;
    end else if (wr_en_i) begin
      unique case (sel_i.tgt)
        TGT_PMR:   pmr_q   <= wdata_i[PMR_W-1:0];
        TGT_BP_S:  bp_s_q  <= clamp_bp(wdata_i[BP_W-1:0], MIN_BP_S);
        TGT_BP_NS: bp_ns_q <= clamp_bp(wdata_i[BP_W-1:0], MIN_BP_NS);
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_APR; i++) begin : g_apr
    logic [DATA_W-1:0] apr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        apr_q <= '0;
      else if (wr_en_i && sel_i.tgt == TGT_APR && sel_i.apr_idx == APR_IDX_W'(i))
        apr_q <= wdata_i;
    end
    assign apr_o[i] = apr_q;
  end

  assign pmr_o   = pmr_q;
  assign bp_s_o  = bp_s_q;
  assign bp_ns_o = bp_ns_q;

  // R4
  bp_ns_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bp_ns_q >= MIN_BP_NS);

  // R8
  bank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable({pmr_q, bp_s_q, bp_ns_q}));

  // R2
  pmr_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_i.tgt != TGT_PMR) |=> $stable(pmr_q));

  // R3
  bp_s_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_i.tgt != TGT_BP_S) |=> $stable(bp_s_q));
endmodule

// File: rtl/bpr_regbank.sv
module bpr_regbank
  import bpr_regbank_pkg::*;
#(
  parameter int unsigned NUM_CPU  = 2,
  parameter int unsigned REVISION = 2,
  parameter bit          SEC_EXT  = 1'b1,
  localparam int unsigned CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [CPU_W-1:0]  cpu_i,
  input  logic              secure_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam bit HAS_GROUPS = (REVISION >= 2) || SEC_EXT;

  sel_t              sel;
  logic              cpu_ok;
  logic [DATA_W-1:0] rd_val;

  logic [PMR_W-1:0]  pmr_w   [NUM_CPU];
  logic [BP_W-1:0]   bp_s_w  [NUM_CPU];
  logic [BP_W-1:0]   bp_ns_w [NUM_CPU];
  logic [DATA_W-1:0] apr_w   [NUM_CPU][NUM_APR];

  assign cpu_ok = int'(cpu_i) < NUM_CPU;

  bpr_decode #(
    .SEC_EXT   (SEC_EXT),
    .HAS_GROUPS(HAS_GROUPS)
  ) u_decode (
    .offset_i(offset_i),
    .secure_i(secure_i),
    .sel_o   (sel)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic wr_en;
    assign wr_en = req_i && we_i && cpu_i == CPU_W'(c);

    bpr_cpu_bank u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_en_i(wr_en),
      .sel_i  (sel),
      .wdata_i(wdata_i),
      .pmr_o  (pmr_w[c]),
      .bp_s_o (bp_s_w[c]),
      .bp_ns_o(bp_ns_w[c]),
      .apr_o  (apr_w[c])
    );
  end

  always_comb begin
    rd_val = '0;
    if (cpu_ok) begin
      unique case (sel.tgt)
        TGT_PMR:   rd_val = DATA_W'(pmr_w[cpu_i]);
        TGT_BP_S:  rd_val = DATA_W'(bp_s_w[cpu_i]);
        TGT_BP_NS: rd_val = DATA_W'(bp_ns_w[cpu_i]);
        TGT_APR:   rd_val = apr_w[cpu_i][sel.apr_idx];
        default:   rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      rdata_o <= '0;
    else if (req_i && !we_i)
      rdata_o <= rd_val;
  end

  // R6
  abp_raz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && offset_i == OFF_ABP && SEC_EXT && !secure_i) |=> rdata_o == '0);

  // R11
  abp_nogroup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && offset_i == OFF_ABP && !HAS_GROUPS) |=> rdata_o == '0);

  // R9
  unmapped_raz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && sel.tgt == TGT_NONE) |=> rdata_o == '0);

  // R10
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));

  // R4
  bp_read_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && sel.tgt == TGT_BP_NS) |=> rdata_o != '0);
endmodule

// File: tb/bpr_regbank_tb.sv
`timescale 1ns/1ps
module bpr_regbank_tb;
  localparam int NCFG = 3;
  localparam int NCPU = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, sec = 1'b0;
  logic [0:0]  cpu = '0;
  logic [11:0] off = '0;
  logic [31:0] wd = '0;
  logic [31:0] rd [NCFG];

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // cfg0: security, rev 2; cfg1: no security, rev 2; cfg2: no security, rev 1
  bit cfg_sec [NCFG] = '{1'b1, 1'b0, 1'b0};
  bit cfg_grp [NCFG] = '{1'b1, 1'b1, 1'b0};

  logic [7:0]  m_pmr [NCFG][NCPU];
  logic [2:0]  m_bs  [NCFG][NCPU];
  logic [2:0]  m_bn  [NCFG][NCPU];
  logic [31:0] m_apr [NCFG][NCPU][4];

  always #2.5 clk = ~clk;

  bpr_regbank #(.NUM_CPU(NCPU), .REVISION(2), .SEC_EXT(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .cpu_i(cpu),
    .secure_i(sec), .offset_i(off), .wdata_i(wd), .rdata_o(rd[0]));
  bpr_regbank #(.NUM_CPU(NCPU), .REVISION(2), .SEC_EXT(1'b0)) u_dut_nosec (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .cpu_i(cpu),
    .secure_i(sec), .offset_i(off), .wdata_i(wd), .rdata_o(rd[1]));
  bpr_regbank #(.NUM_CPU(NCPU), .REVISION(1), .SEC_EXT(1'b0)) u_dut_v1 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .cpu_i(cpu),
    .secure_i(sec), .offset_i(off), .wdata_i(wd), .rdata_o(rd[2]));

  function automatic bit is_apr(logic [11:0] o);
    return o[11:4] == 8'h0d && o[1:0] == 2'b00;
  endfunction

  function automatic logic [31:0] exp_read(int c, int p, bit s, logic [11:0] o);
    bit nsv = cfg_sec[c] && !s;
    if (o == 12'h004) return {24'd0, m_pmr[c][p]};
    if (o == 12'h008) return {29'd0, nsv ? m_bn[c][p] : m_bs[c][p]};
    if (o == 12'h01c) return (cfg_grp[c] && !nsv) ? {29'd0, m_bn[c][p]} : 32'd0;
    if (is_apr(o)) return m_apr[c][p][o[3:2]];
    return 32'd0;
  endfunction

  function automatic string tag_of(int c, bit s, logic [11:0] o);
    bit nsv = cfg_sec[c] && !s;
    if (o == 12'h004) return "R2";
    if (o == 12'h008) return nsv ? "R4" : "R3";
    if (o == 12'h01c) return !cfg_grp[c] ? "R11" : (nsv ? "R6" : "R5");
    if (is_apr(o)) return "R7";
    return "R9";
  endfunction

  task automatic model_write(int p, bit s, logic [11:0] o, logic [31:0] d);
    for (int c = 0; c < NCFG; c++) begin
      bit nsv = cfg_sec[c] && !s;
      logic [2:0] bn = (d[2:0] == 3'd0) ? 3'd1 : d[2:0];
      if (o == 12'h004) m_pmr[c][p] = d[7:0];
      else if (o == 12'h008) begin
        if (nsv) m_bn[c][p] = bn; else m_bs[c][p] = d[2:0];
      end else if (o == 12'h01c) begin
        if (cfg_grp[c] && !nsv) m_bn[c][p] = bn;
      end else if (is_apr(o)) m_apr[c][p][o[3:2]] = d;
    end
  endtask

  task automatic access(bit w, int p, bit s, logic [11:0] o, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; cpu = 1'(p); sec = s; off = o; wd = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic check_read(int p, bit s, logic [11:0] o, string force_tag);
    access(1'b0, p, s, o, 32'd0);
    for (int c = 0; c < NCFG; c++) begin
      logic [31:0] e = exp_read(c, p, s, o);
      string t = (force_tag != "") ? force_tag : tag_of(c, s, o);
      n_chk++;
      if (rd[c] !== e) begin
        n_fail++;
        $display("FAIL %s cfg%0d cpu%0d sec%0d off=%h: got %h expected %h",
                 t, c, p, s, o, rd[c], e);
      end
    end
  endtask

  logic [11:0] offs [13] = '{12'h000, 12'h004, 12'h008, 12'h00c, 12'h01c, 12'h0d0,
                             12'h0d4, 12'h0d8, 12'h0dc, 12'h0e0, 12'h0d2, 12'h0fc, 12'h100};
  logic [31:0] pats [8]  = '{32'd0, 32'd1, 32'd2, 32'd5, 32'd7, 32'd8,
                             32'hA5C3_96F0, 32'hFFFF_FFFF};

  initial begin
    for (int c = 0; c < NCFG; c++)
      for (int p = 0; p < NCPU; p++) begin
        m_pmr[c][p] = '0; m_bs[c][p] = 3'd0; m_bn[c][p] = 3'd1;
        for (int k = 0; k < 4; k++) m_apr[c][p][k] = '0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int p = 0; p < NCPU; p++)
      for (int s = 0; s < 2; s++)
        for (int i = 0; i < 13; i++) check_read(p, 1'(s), offs[i], "R1");

    // sweep: write each offset/attribute/pattern, read back via both views
    for (int p = 0; p < NCPU; p++)
      for (int s = 0; s < 2; s++)
        for (int i = 0; i < 13; i++)
          for (int k = 0; k < 8; k++) begin
            logic [31:0] d = pats[k] ^ (32'(p) << 12) ^ (32'(i) << 20);
            access(1'b1, p, 1'(s), offs[i], d);
            model_write(p, 1'(s), offs[i], d);
            check_read(p, 1'b0, offs[i], "");
            check_read(p, 1'b1, offs[i], "");
          end

    // R8: distinct per-processor values, then full readback
    access(1'b1, 0, 1'b1, 12'h004, 32'h0000_003C); model_write(0, 1'b1, 12'h004, 32'h3C);
    access(1'b1, 1, 1'b1, 12'h004, 32'h0000_00C3); model_write(1, 1'b1, 12'h004, 32'hC3);
    access(1'b1, 0, 1'b1, 12'h0d8, 32'h1234_5678); model_write(0, 1'b1, 12'h0d8, 32'h1234_5678);
    access(1'b1, 1, 1'b0, 12'h008, 32'h0000_0000); model_write(1, 1'b0, 12'h008, 32'h0);
    for (int p = 0; p < NCPU; p++)
      for (int s = 0; s < 2; s++)
        for (int i = 0; i < 13; i++) check_read(p, 1'(s), offs[i], "R8");

    // R10: read data holds across a following write
    check_read(0, 1'b1, 12'h0d8, "R10");
    access(1'b1, 0, 1'b1, 12'h0d8, 32'hDEAD_BEEF);
    model_write(0, 1'b1, 12'h0d8, 32'hDEAD_BEEF);
    for (int c = 0; c < NCFG; c++) begin
      n_chk++;
      if (rd[c] !== 32'h1234_5678) begin
        n_fail++;
        $display("FAIL R10 cfg%0d hold: got %h expected %h", c, rd[c], 32'h1234_5678);
      end
    end
    check_read(0, 1'b1, 12'h0d8, "R10");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule